// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects a parameterised set of interrupt request lines (64 by default) and folds them into one interrupt output for a processor. Every line has a 2-bit trigger mode (active-low level, active-high level, falling edge or rising edge) and a 3-bit priority level. Level 0 doubles as the per-line disable. Edge events are held in a per-line latch until software clears it with an indexed command word. A threshold register suppresses any winner whose level is not strictly above it, and a global enable gates the output.

Software reaches the block over a simple synchronous register bus. Writes take effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. The status register returns the number of the winning line, or a no-interrupt flag. Request inputs may be asynchronous: each one passes through two flops before it is used.

Top module: `prio_intc`

## Requirements
- R1: After reset the enable bit, the threshold, every mode field and every level field read 0. `cpu_irq` is 0 and the status register (word address 0x03) reads 0x0001_0000.
- R2: Word address 0x00, bit 0, is the global enable. While it is 0, `cpu_irq` is 0 and the status no-interrupt flag is set. A register write changes `cpu_irq` one clock edge after the write edge.
- R3: Mode 00 makes a line pending while its input is 0, and mode 01 while its input is 1. An input change is seen on `cpu_irq` after the third rising clock edge: two synchronizer flops, then the output register.
- R4: Mode 10 latches a falling edge and mode 11 latches a rising edge. Both edges are taken on the synchronized input. A latched line stays pending after its input returns, until the latch is cleared.
- R5: A line whose level field is 0 never asserts `cpu_irq` and never appears in the status register, whatever its input is.
- R6: Among the pending lines with a nonzero level, the highest level wins. When several lines share that level, the lowest-numbered line wins.
- R7: Word address 0x01, bits 2:0, hold a threshold. `cpu_irq` is asserted only when the winner's level is strictly greater than the threshold.
- R8: A write to word address 0x02 clears edge latches. It carries two 16-bit fields, at bit 0 and at bit 16. In each field, bit 8 enables the clear, bits 3:0 give the line within a group of 16, and bit 5 selects lines 32 and up. The field at bit 16 adds 16 to the line number. A field whose bit 8 is 0 does nothing.
- R9: When a clear command for a line arrives on the same edge at which that line's latch is being set by a new edge, the latch stays set.
- R10: The status register reads bit 16 = 1 with bits 5:0 = 0 when no interrupt is asserted. Otherwise it reads bit 16 = 0 with bits 5:0 holding the winning line number.
- R11: Mode fields sit at word 0x04 + i/16, bits 2*(i%16)+1:2*(i%16). The level of line i sits at word 0x10 + 8*i[5] + i[3:1], in byte 2*i[4] + i[0], bits 2:0 of that byte. All these fields read back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| irq_in | input | NSRC | Interrupt request lines, may be asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The bench aims at four corner cases:

- **Equal-level tie.** Two lines share the top level. A comparator that prefers the right-hand operand would report the higher-numbered line.
- **Threshold equal to the winner's level.** An off-by-one in the threshold comparison would still raise `cpu_irq`.
- **Clear on the same edge as a new edge.** A clear that takes priority over the set would lose the second event, and the line would drop out of the status register.
- **Input latency and field placement.** The bench checks the exact three-edge latency from a level input to `cpu_irq`. It also writes level and mode fields, then reads them back at hand-computed word and byte positions. A swapped index bit would show up in that readback, and in which line wins.

// File: rtl/prio_intc_pkg.sv
`timescale 1ns/1ps
package prio_intc_pkg;
  localparam int ADDR_W = 6;
  localparam int BUS_W  = 32;

  localparam logic [ADDR_W-1:0] A_ENABLE = 6'h00;
  localparam logic [ADDR_W-1:0] A_THRESH = 6'h01;
  localparam logic [ADDR_W-1:0] A_ECLR   = 6'h02;
  localparam logic [ADDR_W-1:0] A_STATUS = 6'h03;
  localparam logic [ADDR_W-1:0] A_MODE0  = 6'h04;
  localparam logic [ADDR_W-1:0] A_LEVEL0 = 6'h10;

  localparam int ST_NONE_BIT = 16;
  localparam int ECLR_EN_BIT = 8;
  localparam int ECLR_BANK   = 5;
  localparam int ECLR_HALF   = 16;
endpackage

// File: rtl/prio_intc_regs.sv
`timescale 1ns/1ps
module prio_intc_regs
  import prio_intc_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int LVLW = 3,
  localparam int IDW = $clog2(NSRC)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [BUS_W-1:0]           bus_wdata,
  input  logic                       st_none,
  input  logic [IDW-1:0]             st_id,
  output logic                       en_q,
  output logic [LVLW-1:0]            thr_q,
  output logic [NSRC-1:0][1:0]       mode_q,
  output logic [NSRC-1:0][LVLW-1:0]  lvl_q,
  output logic [NSRC-1:0]            clr_o,
  output logic [BUS_W-1:0]           bus_rdata
);
  // word and byte holding the level of line i
  function automatic int lvl_word(int i);
    return (i / 32) * 8 + (i % 16) / 2;
  endfunction
  function automatic int lvl_byte(int i);
    return ((i / 16) % 2) * 2 + (i % 2);
  endfunction

  logic                      en_d;
  logic [LVLW-1:0]           thr_d;
  logic [NSRC-1:0][1:0]      mode_d;
  logic [NSRC-1:0][LVLW-1:0] lvl_d;

  always_comb begin
    en_d   = en_q;
    thr_d  = thr_q;
    mode_d = mode_q;
    lvl_d  = lvl_q;
    if (bus_wr) begin
      if (bus_addr == A_ENABLE) en_d  = bus_wdata[0];
      if (bus_addr == A_THRESH) thr_d = bus_wdata[LVLW-1:0];
      for (int i = 0; i < NSRC; i++) begin
        if (bus_addr == A_MODE0 + ADDR_W'(i / 16))
          mode_d[i] = bus_wdata[2*(i%16) +: 2];
        if (bus_addr == A_LEVEL0 + ADDR_W'(lvl_word(i)))
          lvl_d[i] = bus_wdata[8*lvl_byte(i) +: LVLW];
      end
    end
  end

  // indexed edge-latch clear, two command fields per word
  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      clr_o[i] = bus_wr && (bus_addr == A_ECLR)
              && bus_wdata[ECLR_HALF*((i/16)%2) + ECLR_EN_BIT]
              && (int'(bus_wdata[ECLR_HALF*((i/16)%2) +: 4]) == (i % 16))
              && (int'(bus_wdata[ECLR_HALF*((i/16)%2) + ECLR_BANK]) == ((i / 32) % 2));
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_ENABLE) bus_rdata[0] = en_q;
    if (bus_addr == A_THRESH) bus_rdata[LVLW-1:0] = thr_q;
    if (bus_addr == A_STATUS) begin
      bus_rdata[ST_NONE_BIT] = st_none;
      bus_rdata[IDW-1:0]     = st_id;
    end
    for (int i = 0; i < NSRC; i++) begin
      if (bus_addr == A_MODE0 + ADDR_W'(i / 16))
        bus_rdata[2*(i%16) +: 2] = mode_q[i];
      if (bus_addr == A_LEVEL0 + ADDR_W'(lvl_word(i)))
        bus_rdata[8*lvl_byte(i) +: LVLW] = lvl_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      thr_q  <= '0;
      mode_q <= '0;
      lvl_q  <= '0;
    end else begin
      en_q   <= en_d;
      thr_q  <= thr_d;
      mode_q <= mode_d;
      lvl_q  <= lvl_d;
    end
  end
endmodule

// File: rtl/prio_intc_detect.sv
`timescale 1ns/1ps
module prio_intc_detect (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irq_raw,
  input  logic [1:0] mode,
  input  logic       clr,
  output logic       pend,
  output logic       evt,
  output logic       latch_q
);
  logic s1_q, s2_q, pv_q;
  logic latch_d;

  always_comb begin
    // mode[1]: edge, mode[0]: active-high / rising
    evt     = mode[1] & (mode[0] ? (s2_q & ~pv_q) : (~s2_q & pv_q));
    latch_d = evt | (latch_q & ~clr);
    pend    = mode[1] ? latch_q : (s2_q == mode[0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b0;
      s2_q    <= 1'b0;
      pv_q    <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      s1_q    <= irq_raw;
      s2_q    <= s1_q;
      pv_q    <= s2_q;
      latch_q <= latch_d;
    end
  end
endmodule

// File: rtl/prio_intc_arb.sv
`timescale 1ns/1ps
module prio_intc_arb #(
  parameter int NSRC = 64,
  parameter int LVLW = 3,
  localparam int IDW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]            pend,
  input  logic [NSRC-1:0][LVLW-1:0]  lvl,
  output logic [LVLW-1:0]            win_lvl,
  output logic [IDW-1:0]             win_id
);
  // heap-ordered comparison tree: leaves at NSRC+i, root at 1
  logic [LVLW-1:0] nl [1:2*NSRC-1];
  logic [IDW-1:0]  ni [1:2*NSRC-1];

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      nl[NSRC+i] = pend[i] ? lvl[i] : '0;
      ni[NSRC+i] = IDW'(i);
    end
    for (int k = NSRC - 1; k >= 1; k--) begin
      if (nl[2*k] >= nl[2*k+1]) begin
        nl[k] = nl[2*k];
        ni[k] = ni[2*k];
      end else begin
        nl[k] = nl[2*k+1];
        ni[k] = ni[2*k+1];
      end
    end
    win_lvl = nl[1];
    win_id  = ni[1];
  end
endmodule

// File: rtl/prio_intc.sv
`timescale 1ns/1ps
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int LVLW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              cpu_irq
);
  localparam int IDW = $clog2(NSRC);

  logic                      en_q;
  logic [LVLW-1:0]           thr_q;
  logic [NSRC-1:0][1:0]      mode_q;
  logic [NSRC-1:0][LVLW-1:0] lvl_q;
  logic [NSRC-1:0]           clr, pend, evt, lt;
  logic [LVLW-1:0]           win_lvl;
  logic [IDW-1:0]            win_id;
  logic                      irq_d;
  logic [IDW-1:0]            id_d;
  logic                      stat_none_q;
  logic [IDW-1:0]            stat_id_q;

  prio_intc_regs #(.NSRC(NSRC), .LVLW(LVLW)) u_regs (
    .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata,
    .st_none(stat_none_q), .st_id(stat_id_q),
    .en_q, .thr_q, .mode_q, .lvl_q, .clr_o(clr), .bus_rdata
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    prio_intc_detect u_det (
      .clk, .rst_n, .irq_raw(irq_in[g]), .mode(mode_q[g]), .clr(clr[g]),
      .pend(pend[g]), .evt(evt[g]), .latch_q(lt[g])
    );
  end

  prio_intc_arb #(.NSRC(NSRC), .LVLW(LVLW)) u_arb (
    .pend, .lvl(lvl_q), .win_lvl, .win_id
  );

  always_comb begin
    irq_d = en_q && (win_lvl > thr_q);
    id_d  = irq_d ? win_id : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_irq     <= 1'b0;
      stat_none_q <= 1'b1;
      stat_id_q   <= '0;
    end else begin
      cpu_irq     <= irq_d;
      stat_none_q <= ~irq_d;
      stat_id_q   <= id_d;
    end
  end
endmodule

// File: rtl/prio_intc_chk.sv
`timescale 1ns/1ps
module prio_intc_chk #(
  parameter int NSRC = 64,
  parameter int LVLW = 3,
  localparam int IDW = $clog2(NSRC)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cpu_irq,
  input logic                      stat_none,
  input logic [IDW-1:0]            stat_id,
  input logic                      en_q,
  input logic [LVLW-1:0]           thr_q,
  input logic [NSRC-1:0][LVLW-1:0] lvl_q,
  input logic [NSRC-1:0]           clr,
  input logic [NSRC-1:0]           evt,
  input logic [NSRC-1:0]           lt
);
  logic [NSRC-1:0][LVLW-1:0] lvl_p;
  logic [LVLW-1:0]           thr_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_p <= '0;
      thr_p <= '0;
    end else begin
      lvl_p <= lvl_q;
      thr_p <= thr_q;
    end
  end

  assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !cpu_irq);

  assert_no_zero_level_win_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (lvl_p[stat_id] != '0));

  assert_above_threshold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (lvl_p[stat_id] > thr_p));

  assert_none_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_none |-> (stat_id == '0));

  assert_latch_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(lt & ~clr)) |=> ((lt | ~$past(lt & ~clr)) == '1));

  assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt & clr)) |=> ((lt | ~$past(evt & clr)) == '1));
endmodule

bind prio_intc prio_intc_chk #(.NSRC(NSRC), .LVLW(LVLW)) u_chk (
  .clk, .rst_n, .cpu_irq, .stat_none(stat_none_q), .stat_id(stat_id_q),
  .en_q, .thr_q, .lvl_q, .clr, .evt, .lt
);

// File: tb/prio_intc_tb_top.sv
`timescale 1ns/1ps
module prio_intc_tb_top;
  localparam int N = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_in = '0;
  logic          bus_wr = 1'b0;
  logic [5:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          cpu_irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  prio_intc dut_i (
    .clk, .rst_n, .irq_in, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata, .cpu_irq
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model, stepped on every rising edge
  int m_mode[N];
  int m_lvl[N];
  bit m_s1[N], m_s2[N], m_pv[N], m_lt[N], m_clr[N];
  int m_en, m_thr;
  bit e_irq;
  int e_id;
  int best, bid, src;
  bit p, ev, nirq;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_mode[i] = 0; m_lvl[i] = 0; m_s1[i] = 0; m_s2[i] = 0; m_pv[i] = 0; m_lt[i] = 0;
      end
      m_en = 0; m_thr = 0; e_irq = 0; e_id = 0;
    end else begin
      best = 0; bid = 0;
      for (int i = 0; i < N; i++) begin
        p = (m_mode[i] >= 2) ? m_lt[i] : (int'(m_s2[i]) == m_mode[i] % 2);
        if (p && m_lvl[i] > best) begin best = m_lvl[i]; bid = i; end
      end
      nirq = (m_en != 0) && (best > m_thr);
      for (int i = 0; i < N; i++) m_clr[i] = 0;
      if (bus_wr && bus_addr == 6'h02)
        for (int h = 0; h < 2; h++)
          if (bus_wdata[16*h+8]) begin
            src = int'(bus_wdata[16*h+5]) * 32 + h * 16 + int'(bus_wdata[16*h +: 4]);
            m_clr[src] = 1;
          end
      for (int i = 0; i < N; i++) begin
        ev = (m_mode[i] == 3) ? (m_s2[i] && !m_pv[i]) :
             (m_mode[i] == 2) ? (!m_s2[i] && m_pv[i]) : 1'b0;
        m_lt[i] = ev || (m_lt[i] && !m_clr[i]);
        m_pv[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = irq_in[i];
      end
      if (bus_wr) begin
        if (bus_addr == 6'h00) m_en = int'(bus_wdata[0]);
        if (bus_addr == 6'h01) m_thr = int'(bus_wdata[2:0]);
        if (bus_addr >= 6'h04 && bus_addr <= 6'h07)
          for (int j = 0; j < 16; j++)
            m_mode[(int'(bus_addr) - 4) * 16 + j] = int'(bus_wdata[2*j +: 2]);
        if (bus_addr >= 6'h10 && bus_addr <= 6'h1f)
          for (int b = 0; b < 4; b++) begin
            src = ((int'(bus_addr) - 16) / 8) * 32 + (b / 2) * 16 + ((int'(bus_addr) - 16) % 8) * 2 + b % 2;
            m_lvl[src] = int'(bus_wdata[8*b +: 3]);
          end
      end
      e_irq = nirq;
      e_id  = nirq ? bid : 0;
    end
  end

  // cycle-by-cycle comparison against the model (R3, R6, R7 combined)
  always @(negedge clk) begin
    if (rst_n) chk(cpu_irq === e_irq, "R3/R6/R7 model cpu_irq", cpu_irq, e_irq);
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rdc(input logic [5:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(bus_rdata === e, tag, bus_rdata, e);
  endtask

  task automatic setlvl(input int i, input int l);
    int w; logic [31:0] d; int s;
    w = (i / 32) * 8 + (i % 16) / 2;
    d = '0;
    for (int b = 0; b < 4; b++) begin
      s = (w / 8) * 32 + (b / 2) * 16 + (w % 8) * 2 + b % 2;
      d[8*b +: 8] = 8'((s == i) ? l : m_lvl[s]);
    end
    wr(6'(16 + w), d);
  endtask

  task automatic setmode(input int i, input int m);
    logic [31:0] d; int s;
    d = '0;
    for (int j = 0; j < 16; j++) begin
      s = (i / 16) * 16 + j;
      d[2*j +: 2] = 2'((s == i) ? m : m_mode[s]);
    end
    wr(6'(4 + i / 16), d);
  endtask

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(cpu_irq === 1'b0, "R1 cpu_irq after reset", cpu_irq, 0);
    rdc(6'h00, 32'h0, "R1 enable");
    rdc(6'h01, 32'h0, "R1 threshold");
    rdc(6'h04, 32'h0, "R1 mode word 0");
    rdc(6'h07, 32'h0, "R1 mode word 3");
    rdc(6'h10, 32'h0, "R1 level word 0");
    rdc(6'h1f, 32'h0, "R1 level word 15");
    rdc(6'h03, 32'h0001_0000, "R1 status");

    // R5: enabled, every line pending but level 0
    wr(6'h00, 32'h1);
    idle(2);
    rdc(6'h03, 32'h0001_0000, "R5 all levels zero");
    chk(cpu_irq === 1'b0, "R5 cpu_irq", cpu_irq, 0);

    // R3 / R10: line 5 low-active, input low
    setlvl(5, 3);
    rdc(6'h03, 32'h0000_0005, "R10 status line 5");
    chk(cpu_irq === 1'b1, "R3 low-active pending", cpu_irq, 1);
    irq_in[5] = 1'b1;
    @(negedge clk); chk(cpu_irq === 1'b1, "R3 latency edge 1", cpu_irq, 1);
    @(negedge clk); chk(cpu_irq === 1'b1, "R3 latency edge 2", cpu_irq, 1);
    @(negedge clk); chk(cpu_irq === 1'b0, "R3 latency edge 3", cpu_irq, 0);
    rdc(6'h03, 32'h0001_0000, "R10 status none");

    // R3 high-active, R6 tie and priority
    setmode(9, 1);
    setlvl(9, 3);
    idle(4);
    rdc(6'h03, 32'h0001_0000, "R3 high-active idle");
    irq_in[9] = 1'b1;
    idle(4);
    rdc(6'h03, 32'h0000_0009, "R3 high-active pending");
    irq_in[5] = 1'b0;
    idle(4);
    rdc(6'h03, 32'h0000_0005, "R6 tie lower number");
    setlvl(9, 4);
    rdc(6'h03, 32'h0000_0009, "R6 higher level");

    // R7 threshold
    wr(6'h01, 32'h4);
    rdc(6'h03, 32'h0001_0000, "R7 level equal to threshold");
    chk(cpu_irq === 1'b0, "R7 cpu_irq equal", cpu_irq, 0);
    wr(6'h01, 32'h3);
    rdc(6'h03, 32'h0000_0009, "R7 level above threshold");

    // R2 global enable
    wr(6'h00, 32'h0);
    rdc(6'h03, 32'h0001_0000, "R2 disabled status");
    chk(cpu_irq === 1'b0, "R2 disabled cpu_irq", cpu_irq, 0);
    wr(6'h00, 32'h1);
    rdc(6'h03, 32'h0000_0009, "R2 re-enabled");

    // R4 rising edge latched, R8 clear
    setmode(40, 3);
    setlvl(40, 7);
    rdc(6'h03, 32'h0000_0009, "R4 no edge yet");
    irq_in[40] = 1'b1;
    idle(2);
    irq_in[40] = 1'b0;
    idle(6);
    rdc(6'h03, 32'h0000_0028, "R4 rising latched");
    wr(6'h02, 32'h0000_0128);
    rdc(6'h03, 32'h0000_0009, "R8 clear line 40");

    // R4 falling edge, R8 upper field and enable bit
    irq_in[20] = 1'b1;
    idle(4);
    setmode(20, 2);
    setlvl(20, 6);
    rdc(6'h03, 32'h0000_0009, "R4 falling no edge yet");
    irq_in[20] = 1'b0;
    idle(5);
    rdc(6'h03, 32'h0000_0014, "R4 falling latched");
    wr(6'h02, 32'h0004_0000);
    rdc(6'h03, 32'h0000_0014, "R8 clear without enable ignored");
    wr(6'h02, 32'h0104_0000);
    rdc(6'h03, 32'h0000_0009, "R8 clear upper field");

    // R9 clear on the same edge as a new rising edge
    irq_in[40] = 1'b1;
    @(negedge clk);
    wr(6'h02, 32'h0000_0128);
    rdc(6'h03, 32'h0000_0028, "R9 latch kept");
    wr(6'h02, 32'h0000_0128);
    rdc(6'h03, 32'h0000_0009, "R9 later clear works");

    // R11 field placement, R6 with more lines
    setlvl(17, 5);
    setlvl(33, 2);
    rdc(6'h03, 32'h0000_0011, "R6 line 17 wins");
    rdc(6'h10, 32'h0500_0000, "R11 level word 0x10");
    rdc(6'h12, 32'h0006_0300, "R11 level word 0x12");
    rdc(6'h14, 32'h0000_0400, "R11 level word 0x14");
    rdc(6'h18, 32'h0000_0200, "R11 level word 0x18");
    rdc(6'h1c, 32'h0000_0007, "R11 level word 0x1c");
    rdc(6'h04, 32'h0004_0000, "R11 mode word 0x04");
    rdc(6'h05, 32'h0000_0200, "R11 mode word 0x05");
    rdc(6'h06, 32'h0003_0000, "R11 mode word 0x06");
    rdc(6'h07, 32'h0000_0000, "R11 mode word 0x07");
    rdc(6'h00, 32'h0000_0001, "R11 enable readback");
    rdc(6'h01, 32'h0000_0003, "R11 threshold readback");

    // R5 disabling the current winner
    setlvl(17, 0);
    rdc(6'h03, 32'h0000_0009, "R5 winner disabled");
    idle(3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule